// File: doc/BRIEF.md
# Li-Ion Charge Cycle Sequencer

This block is the digital sequencer of a battery charger. A set of analog comparators reports the battery and input conditions as single-bit flags. From these flags, the enable and mode-select pins and one configuration bit, the sequencer chooses which current mode the analog stage applies: off, low-current precharge, constant current, constant voltage or pass-through regulator (LDO). It also drives a red and a green active-low indicator, a charge-complete flag and a fault flag.

A Li-Ion cycle starts in precharge. It moves to constant current once the battery clears the precharge level, then to constant voltage at the regulation level. It enters maintenance when the taper current falls below the selected end-of-charge fraction. From maintenance it restarts when the battery sags below the restart level. A safety timer runs only while constant current is active. It counts a prescaled tick input and, when it expires, either latches a fault or moves the sequencer to maintenance, depending on a stop pin. With the Ni-MH configuration, the sequencer holds constant voltage with neither end-of-charge detection nor timer.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: After reset, and one clock after `adapterOk` is low in any state, `driveMode` is 0 (off), both LEDs are dark (high), both flags are low and the safety timer is cleared. `driveMode` codes are 0 off, 1 precharge, 2 constant current, 3 constant voltage and 4 LDO.
- R2: With the adapter OK, enabled, `ldoSelect` low and `cfgNimh` low, the sequencer leaves off for precharge (`driveMode`=1) one clock later, with the red LED lit (low) and the green LED dark.
- R3: In precharge, `battAbovePre` high moves the sequencer to constant current (`driveMode`=2) at the next clock.
- R4: In constant current, `battAtReg` high moves the sequencer to constant voltage (`driveMode`=3) at the next clock, unless the timer has expired.
- R5: In constant voltage, `currBelowEoc` high moves the sequencer to maintenance at the next clock: `driveMode`=0, `eocFlag` high, green LED lit, red LED dark.
- R6: In maintenance, `battBelowRestart` high restarts the sequencer in precharge at the next clock. In this recharge and its later constant-current and constant-voltage phases, the green LED is lit and the red LED is dark, until the adapter is lost.
- R7: The safety timer clears whenever the sequencer is outside constant current and counts `timerTick` pulses inside it. After `TIMER_TICKS` counted ticks it expires. With `timerStopN` high, the sequencer goes to fault one clock later: `driveMode`=0, `faultFlag` high, both LEDs lit.
- R8: When the timer expires with `timerStopN` low, the sequencer goes to maintenance instead (`eocFlag` high, green LED lit).
- R9: Fault persists whatever the comparator flags and `ldoSelect` do. It is left only on loss of `adapterOk` or on `chgEnable` low.
- R10: With `cfgNimh` high, a start enters constant voltage directly (`driveMode`=3, red LED lit). `currBelowEoc` and `timerTick` have no effect there: no maintenance, no fault.
- R11: `ldoSelect` high (with the adapter OK and enabled) selects LDO mode (`driveMode`=4) one clock later, with both LEDs dark. Dropping it restarts a charge cycle.
- R12: `chgEnable` low forces `driveMode`=0 with only the green LED lit, one clock later. This holds in charger and LDO modes, and it overrides `ldoSelect`.
- R13: Each entry into constant current starts the timer from zero. Ticks seen in precharge, constant voltage or maintenance are not counted, so a re-entered constant-current phase lasts the full `TIMER_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adapterOk | input | 1 | Input supply inside its lockout window |
| battAbovePre | input | 1 | Battery above precharge exit level |
| battAtReg | input | 1 | Battery at selected regulation voltage |
| currBelowEoc | input | 1 | Charge current below selected end-of-charge fraction |
| battBelowRestart | input | 1 | Battery below restart level |
| chgEnable | input | 1 | Charger enable, high active |
| ldoSelect | input | 1 | High selects LDO mode (no battery identified) |
| timerStopN | input | 1 | High: timer expiry is a fault; low: expiry goes to maintenance |
| cfgNimh | input | 1 | Configuration: 1 selects Ni-MH constant-voltage charging |
| timerTick | input | 1 | Prescaled safety-timer tick enable |
| driveMode | output | 3 | Current-mode select for the analog stage |
| redLedN | output | 1 | Red indicator, active low |
| greenLedN | output | 1 | Green indicator, active low |
| eocFlag | output | 1 | Maintenance (charge complete) status |
| faultFlag | output | 1 | Safety-timer fault status |

## Verification
The state register is the only register between the inputs and every output except the timer, so a change of mode, LED pattern or flag is due one clock after the input that causes it. The bench drives inputs just after a falling edge and samples one rising edge later, at the next falling edge. The timer adds its own count. With the tick held high, the constant-current phase lasts `TIMER_TICKS` clocks after the entry edge, and the fault or maintenance outcome shows at the clock after that. The bench checks the mode both at the last clock of that window and at the first clock after it.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PRE,
    ST_CC,
    ST_CV,
    ST_MAINT,
    ST_NIMH,
    ST_LDO,
    ST_DIS,
    ST_FAULT
  } chgState_e;

  typedef enum logic [2:0] {
    DRV_OFF = 3'd0,
    DRV_PRE = 3'd1,
    DRV_CC  = 3'd2,
    DRV_CV  = 3'd3,
    DRV_LDO = 3'd4
  } drvMode_e;

  typedef struct packed {
    logic timerClear;
    logic timerRun;
  } tmrStrobe_t;

endpackage

// File: rtl/chg_cycle_fsm.sv
module chg_cycle_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       adapterOk,
  input  logic       battAbovePre,
  input  logic       battAtReg,
  input  logic       currBelowEoc,
  input  logic       battBelowRestart,
  input  logic       chgEnable,
  input  logic       ldoSelect,
  input  logic       timerStopN,
  input  logic       cfgNimh,
  input  logic       timerDone,
  output chgState_e  state,
  output logic       afterMaint,
  output tmrStrobe_t strobe
);

  chgState_e nextState;

  // Start point after off, disabled or LDO.
  function automatic chgState_e startState(input logic nimh);
    return nimh ? ST_NIMH : ST_PRE;
  endfunction

  always_comb begin
    nextState = state;
    if (!adapterOk) begin
      nextState = ST_OFF;
    end else if (!chgEnable) begin
      nextState = ST_DIS;
    end else if (state == ST_FAULT) begin
      nextState = ST_FAULT;
    end else if (ldoSelect) begin
      nextState = ST_LDO;
    end else begin
      unique case (state)
        ST_OFF, ST_DIS, ST_LDO: nextState = startState(cfgNimh);
        ST_PRE:   if (battAbovePre) nextState = ST_CC;
        ST_CC: begin
          if (timerDone)      nextState = timerStopN ? ST_FAULT : ST_MAINT;
          else if (battAtReg) nextState = ST_CV;
        end
        ST_CV:    if (currBelowEoc) nextState = ST_MAINT;
        ST_MAINT: if (battBelowRestart) nextState = ST_PRE;
        ST_NIMH:  nextState = ST_NIMH;
        default:  nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      afterMaint <= 1'b0;
    end else begin
      state <= nextState;
      if (!adapterOk)
        afterMaint <= 1'b0;
      else if (state == ST_MAINT && nextState == ST_PRE)
        afterMaint <= 1'b1;
    end
  end

  always_comb begin
    strobe.timerRun   = (state == ST_CC);
    strobe.timerClear = (state != ST_CC);
  end

  assert_adapter_loss_R1: assert property (@(posedge clk) disable iff (!rstN)
    !adapterOk |=> state == ST_OFF);

  assert_pre_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && battAbovePre && adapterOk && chgEnable && !ldoSelect)
      |=> state == ST_CC);

  assert_expiry_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CC && timerDone && adapterOk && chgEnable && !ldoSelect && timerStopN)
      |=> state == ST_FAULT);

  assert_expiry_maint_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CC && timerDone && adapterOk && chgEnable && !ldoSelect && !timerStopN)
      |=> state == ST_MAINT);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && adapterOk && chgEnable) |=> state == ST_FAULT);

  assert_nimh_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NIMH && adapterOk && chgEnable && !ldoSelect) |=> state == ST_NIMH);

  assert_disable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (adapterOk && !chgEnable) |=> state == ST_DIS);

endmodule

// File: rtl/chg_cycle_dp.sv
module chg_cycle_dp
  import chg_pkg::*;
#(
  parameter int TIMER_TICKS = 20160
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strobe,
  input  logic       timerTick,
  input  chgState_e  state,
  input  logic       afterMaint,
  output logic       timerDone,
  output logic [2:0] driveMode,
  output logic       redLedN,
  output logic       greenLedN,
  output logic       eocFlag,
  output logic       faultFlag
);

  localparam int CNT_W = $clog2(TIMER_TICKS + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMER_TICKS);

  logic [CNT_W-1:0] tmrCount;
  logic redOn, greenOn;
  drvMode_e modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tmrCount <= '0;
    else if (strobe.timerClear)
      tmrCount <= '0;
    else if (strobe.timerRun && timerTick && !timerDone)
      tmrCount <= tmrCount + 1'b1;
  end

  assign timerDone = (tmrCount == TERM);

  always_comb begin
    modeSel = DRV_OFF;
    redOn   = 1'b0;
    greenOn = 1'b0;
    unique case (state)
      ST_PRE: begin
        modeSel = DRV_PRE;
        redOn = !afterMaint; greenOn = afterMaint;
      end
      ST_CC: begin
        modeSel = DRV_CC;
        redOn = !afterMaint; greenOn = afterMaint;
      end
      ST_CV: begin
        modeSel = DRV_CV;
        redOn = !afterMaint; greenOn = afterMaint;
      end
      ST_NIMH:  begin modeSel = DRV_CV; redOn = 1'b1; end
      ST_MAINT: greenOn = 1'b1;
      ST_DIS:   greenOn = 1'b1;
      ST_FAULT: begin redOn = 1'b1; greenOn = 1'b1; end
      ST_LDO:   modeSel = DRV_LDO;
      default:  modeSel = DRV_OFF;
    endcase
  end

  assign driveMode = modeSel;
  assign redLedN   = !redOn;
  assign greenLedN = !greenOn;
  assign eocFlag   = (state == ST_MAINT);
  assign faultFlag = (state == ST_FAULT);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.timerRun && timerTick && !timerDone) |=> tmrCount == $past(tmrCount) + 1'b1);

  assert_count_clear_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timerClear |=> tmrCount == '0);

  assert_ldo_dark_R11: assert property (@(posedge clk) disable iff (!rstN)
    (driveMode == 3'd4) |-> (redLedN && greenLedN));

  assert_fault_leds_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> (!redLedN && !greenLedN && driveMode == 3'd0));

endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int TIMER_TICKS = 20160
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adapterOk,
  input  logic       battAbovePre,
  input  logic       battAtReg,
  input  logic       currBelowEoc,
  input  logic       battBelowRestart,
  input  logic       chgEnable,
  input  logic       ldoSelect,
  input  logic       timerStopN,
  input  logic       cfgNimh,
  input  logic       timerTick,
  output logic [2:0] driveMode,
  output logic       redLedN,
  output logic       greenLedN,
  output logic       eocFlag,
  output logic       faultFlag
);

  chgState_e  state;
  logic       afterMaint;
  logic       timerDone;
  tmrStrobe_t strobe;

  chg_cycle_fsm u_fsm (
    .clk              (clk),
    .rstN             (rstN),
    .adapterOk        (adapterOk),
    .battAbovePre     (battAbovePre),
    .battAtReg        (battAtReg),
    .currBelowEoc     (currBelowEoc),
    .battBelowRestart (battBelowRestart),
    .chgEnable        (chgEnable),
    .ldoSelect        (ldoSelect),
    .timerStopN       (timerStopN),
    .cfgNimh          (cfgNimh),
    .timerDone        (timerDone),
    .state            (state),
    .afterMaint       (afterMaint),
    .strobe           (strobe)
  );

  chg_cycle_dp #(.TIMER_TICKS(TIMER_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .timerTick  (timerTick),
    .state      (state),
    .afterMaint (afterMaint),
    .timerDone  (timerDone),
    .driveMode  (driveMode),
    .redLedN    (redLedN),
    .greenLedN  (greenLedN),
    .eocFlag    (eocFlag),
    .faultFlag  (faultFlag)
  );

endmodule

// File: tb/chg_cycle_ctrl_bench.sv
module chg_cycle_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adapterOk = 0, battAbovePre = 0, battAtReg = 0, currBelowEoc = 0;
  logic battBelowRestart = 0, chgEnable = 1, ldoSelect = 0, timerStopN = 1;
  logic cfgNimh = 0, timerTick = 0;
  logic [2:0] driveMode;
  logic redLedN, greenLedN, eocFlag, faultFlag;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_cycle_ctrl #(.TIMER_TICKS(TICKS)) u_chg_cycle_ctrl (
    .clk(clk), .rstN(rstN), .adapterOk(adapterOk), .battAbovePre(battAbovePre),
    .battAtReg(battAtReg), .currBelowEoc(currBelowEoc),
    .battBelowRestart(battBelowRestart), .chgEnable(chgEnable),
    .ldoSelect(ldoSelect), .timerStopN(timerStopN), .cfgNimh(cfgNimh),
    .timerTick(timerTick), .driveMode(driveMode), .redLedN(redLedN),
    .greenLedN(greenLedN), .eocFlag(eocFlag), .faultFlag(faultFlag)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // mode, red, green, eoc, fault
  task automatic chkAll(input string req, input int m, input int r, input int g,
                        input int e, input int f);
    chk({req, " mode"}, driveMode, m);
    chk({req, " redLedN"}, redLedN, r);
    chk({req, " greenLedN"}, greenLedN, g);
    chk({req, " eocFlag"}, eocFlag, e);
    chk({req, " faultFlag"}, faultFlag, f);
  endtask

  task automatic quiet();
    adapterOk = 0; battAbovePre = 0; battAtReg = 0; currBelowEoc = 0;
    battBelowRestart = 0; chgEnable = 1; ldoSelect = 0; timerStopN = 1;
    cfgNimh = 0; timerTick = 0;
    step(1);
  endtask

  task automatic t_reset();
    step(2);
    chkAll("R1 reset", 0, 1, 1, 0, 0);
    rstN = 1'b1;
    step(1);
    chkAll("R1 no adapter", 0, 1, 1, 0, 0);
  endtask

  task automatic t_normalCycle();
    quiet();
    adapterOk = 1; step(1);
    chkAll("R2 start precharge", 1, 0, 1, 0, 0);
    battAbovePre = 1; step(1);
    chkAll("R3 constant current", 2, 0, 1, 0, 0);
    battAtReg = 1; step(1);
    chkAll("R4 constant voltage", 3, 0, 1, 0, 0);
    battAtReg = 0; currBelowEoc = 1; step(1);
    chkAll("R5 maintenance", 0, 1, 0, 1, 0);
    currBelowEoc = 0; battBelowRestart = 1; step(1);
    chkAll("R6 recharge precharge", 1, 1, 0, 0, 0);
    battBelowRestart = 0; step(1);
    chkAll("R6 recharge cc", 2, 1, 0, 0, 0);
    adapterOk = 0; step(1);
    chkAll("R1 adapter loss", 0, 1, 1, 0, 0);
  endtask

  task automatic t_timerFault();
    quiet();
    adapterOk = 1; battAbovePre = 1; timerTick = 1; step(1);
    chkAll("R13 precharge ticks ignored", 1, 0, 1, 0, 0);
    step(1);
    chk("R7 enter cc", driveMode, 2);
    step(TICKS);
    chk("R7 cc before expiry", driveMode, 2);
    step(1);
    chkAll("R7 fault", 0, 0, 0, 0, 1);
    ldoSelect = 1; battAtReg = 1; step(3);
    chkAll("R9 fault held", 0, 0, 0, 0, 1);
    ldoSelect = 0; chgEnable = 0; step(1);
    chkAll("R12 disabled clears fault", 0, 1, 0, 0, 0);
    chgEnable = 1; battAtReg = 0; battAbovePre = 0; step(1);
    chk("R9 restart after enable toggle", driveMode, 1);
    adapterOk = 0; step(1);
  endtask

  task automatic t_bypass();
    quiet();
    adapterOk = 1; battAbovePre = 1; timerTick = 1; timerStopN = 0;
    step(2);
    chk("R8 enter cc", driveMode, 2);
    step(TICKS);
    chk("R8 cc before expiry", driveMode, 2);
    step(1);
    chkAll("R8 expiry to maintenance", 0, 1, 0, 1, 0);
  endtask

  task automatic t_timerRestart();
    quiet();
    adapterOk = 1; battAbovePre = 1; timerTick = 1;
    step(2);
    step(TICKS - 2);
    chk("R13 first cc", driveMode, 2);
    battAtReg = 1; step(1);
    chk("R13 to cv", driveMode, 3);
    battAtReg = 0; currBelowEoc = 1; step(1);
    chk("R13 to maint", eocFlag, 1);
    currBelowEoc = 0; battBelowRestart = 1; step(1);
    chk("R13 restart", driveMode, 1);
    battBelowRestart = 0; step(1);
    chk("R13 re-enter cc", driveMode, 2);
    step(TICKS);
    chkAll("R13 full window after re-entry", 2, 1, 0, 0, 0);
    step(1);
    chk("R13 fault after full window", faultFlag, 1);
  endtask

  task automatic t_nimh();
    quiet();
    cfgNimh = 1; adapterOk = 1; step(1);
    chkAll("R10 nimh cv", 3, 0, 1, 0, 0);
    currBelowEoc = 1; timerTick = 1; battAbovePre = 1; step(2 * TICKS + 4);
    chkAll("R10 no eoc no timer", 3, 0, 1, 0, 0);
  endtask

  task automatic t_ldo();
    quiet();
    ldoSelect = 1; adapterOk = 1; step(1);
    chkAll("R11 ldo", 4, 1, 1, 0, 0);
    chgEnable = 0; step(1);
    chkAll("R12 disable overrides ldo", 0, 1, 0, 0, 0);
    chgEnable = 1; step(1);
    chk("R11 ldo again", driveMode, 4);
    ldoSelect = 0; step(1);
    chkAll("R11 leave ldo restarts", 1, 0, 1, 0, 0);
    ldoSelect = 1; step(1);
    adapterOk = 0; step(1);
    chkAll("R1 adapter loss from ldo", 0, 1, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_normalCycle();
    t_timerFault();
    t_bypass();
    t_timerRestart();
    t_nimh();
    t_ldo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule